// File: doc/BRIEF.md
# Prescaled Reload Countdown Timer

This block is a reload down-counter whose tick comes from a power-of-two divider on the carrier-rate clock. A start event loads the counter from the reload input and clears the divider. The counter then steps down by one on every tick. There are three start sources: a software strobe, the first transmitted bit, and the start of reception. The last two each act only when their own enable is set.

When the count runs out, the block gives a single-cycle expiry pulse. It then either stops or, if auto-restart is set, reloads and keeps running. A software stop freezes the count at once. Software can use the running flag and the live count to time frames and response windows. The expiry pulse can drive an interrupt controller.

Top module: `tick_reload_timer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the count is 0, the running flag is 0 and the expiry pulse is 0.
- R2: With an effective exponent e, the count drops by exactly one every 2^e clock cycles. The first drop comes 2^e cycles after the edge that sampled the start.
- R3: A start event (with no stop in the same cycle) makes the running flag 1 and the count equal to the reload value in the cycle after it is sampled.
- R4: A first-transmitted-bit strobe starts the timer only when the transmit auto-start enable is 1. When that enable is 0, the strobe leaves the running flag and the count unchanged.
- R5: A reception-begin strobe starts the timer only when the receive auto-start enable is 1. When that enable is 0, the strobe has no effect.
- R6: A stop strobe clears the running flag in the next cycle and freezes the count at its current value. Stop wins over any start in the same cycle.
- R7: When a tick arrives while the count is 1 or 0 and auto-restart is 0, the count becomes 0, the running flag clears and the expiry pulse is high for exactly one cycle. A reload value of 0 therefore expires at the first tick.
- R8: When auto-restart is 1 at expiry, the expiry pulse still fires, but the count is reloaded and the running flag stays 1.
- R9: A start while already running reloads the count and restarts the divider. The next drop comes a full 2^e cycles after the restart.
- R10: Exponent values above the parameter MAX_EXP (default 21) act as MAX_EXP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_exp | input | 5 | Tick period exponent (period 2^div_exp cycles, clamped) |
| reload_val | input | 8 | Value loaded on start and on auto-restart |
| sw_start | input | 1 | Software start strobe |
| sw_stop | input | 1 | Software immediate stop strobe |
| tx_auto_en | input | 1 | Enable start on first transmitted bit |
| tx_first_bit | input | 1 | Strobe: first valid bit has been sent |
| rx_auto_en | input | 1 | Enable start on reception begin |
| rx_begin | input | 1 | Strobe: reception has begun |
| auto_restart | input | 1 | Reload and continue on expiry |
| count | output | 8 | Current count |
| running | output | 1 | Timer active flag |
| expire_pulse | output | 1 | One-cycle expiry pulse |

## Verification
Directed sequences cover each corner on its own: the exact tick grid at a nonzero exponent, a restart part-way through a period, a reload of 0, and a start and a stop in the same cycle. They also cover strobes with their enables off, and auto-restart at the shortest period, where expiries come back to back. A long random phase then mixes starts, stops, both event strobes, changing enables, reload values and exponents 0 to 3. A per-cycle reference model checks this phase, which shows whether divider clearing and priority stay right when events overlap. A second instance with a small exponent limit shows the clamp, which is far too slow to observe at the default limit.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned TMR_CNT_W   = 8;
  localparam int unsigned TMR_EXP_W   = 5;
  localparam int unsigned TMR_MAX_EXP = 21;

  // Decoded control for one cycle
  typedef struct packed {
    logic load;
    logic halt;
  } tmr_ctl_t;
endpackage

// File: rtl/tmr_start_ctrl.sv
module tmr_start_ctrl
  import tmr_pkg::*;
(
  input  logic     sw_start,
  input  logic     sw_stop,
  input  logic     tx_auto_en,
  input  logic     tx_first_bit,
  input  logic     rx_auto_en,
  input  logic     rx_begin,
  output tmr_ctl_t ctl
);
  logic any_start;

  always_comb begin
    any_start = sw_start
              | (tx_auto_en & tx_first_bit)
              | (rx_auto_en & rx_begin);
    ctl.halt  = sw_stop;
    ctl.load  = any_start & ~sw_stop;   // stop has priority
  end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned EXP_W   = 5,
  parameter int unsigned MAX_EXP = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EXP_W-1:0] exp_i,
  input  logic             clr_i,
  input  logic             en_i,
  output logic             tick_o
);
  localparam int unsigned DIV_W = (MAX_EXP > 0) ? MAX_EXP : 1;

  logic [EXP_W-1:0] eff_exp;
  logic [DIV_W-1:0] mask;
  logic [DIV_W-1:0] div_q, div_d;
  logic             match;

  always_comb begin
    if (exp_i > EXP_W'(MAX_EXP)) eff_exp = EXP_W'(MAX_EXP);
    else                         eff_exp = exp_i;
  end

  // Bit g of the mask is set when g is below the effective exponent
  for (genvar g = 0; g < DIV_W; g++) begin : g_mask
    assign mask[g] = (32'(eff_exp) > g);
  end

  always_comb begin
    match  = ((div_q & mask) == mask);
    tick_o = en_i & match;
    div_d  = div_q;
    if (clr_i)      div_d = '0;
    else if (en_i)  div_d = match ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/tmr_down_counter.sv
module tmr_down_counter
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmr_ctl_t         ctl,
  input  logic             tick,
  input  logic             auto_restart,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             irq_q, irq_d;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    irq_d = 1'b0;
    if (ctl.halt) begin
      run_d = 1'b0;
    end else if (ctl.load) begin
      cnt_d = reload_val;
      run_d = 1'b1;
    end else if (run_q && tick) begin
      if (cnt_q <= CNT_W'(1)) begin
        irq_d = 1'b1;
        if (auto_restart) begin
          cnt_d = reload_val;
        end else begin
          cnt_d = '0;
          run_d = 1'b0;
        end
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
      irq_q <= irq_d;
    end
  end

  assign count   = cnt_q;
  assign running = run_q;
  assign expire  = irq_q;
endmodule

// File: rtl/tick_reload_timer.sv
module tick_reload_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W   = TMR_CNT_W,
  parameter int unsigned EXP_W   = TMR_EXP_W,
  parameter int unsigned MAX_EXP = TMR_MAX_EXP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EXP_W-1:0] div_exp,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             sw_start,
  input  logic             sw_stop,
  input  logic             tx_auto_en,
  input  logic             tx_first_bit,
  input  logic             rx_auto_en,
  input  logic             rx_begin,
  input  logic             auto_restart,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             expire_pulse
);
  tmr_ctl_t ctl;
  logic     tick;
  logic     div_en;

  tmr_start_ctrl u_start (
    .sw_start     (sw_start),
    .sw_stop      (sw_stop),
    .tx_auto_en   (tx_auto_en),
    .tx_first_bit (tx_first_bit),
    .rx_auto_en   (rx_auto_en),
    .rx_begin     (rx_begin),
    .ctl          (ctl)
  );

  assign div_en = running & ~ctl.halt;

  tmr_prescaler #(.EXP_W(EXP_W), .MAX_EXP(MAX_EXP)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .exp_i  (div_exp),
    .clr_i  (ctl.load),
    .en_i   (div_en),
    .tick_o (tick)
  );

  tmr_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl          (ctl),
    .tick         (tick),
    .auto_restart (auto_restart),
    .reload_val   (reload_val),
    .count        (count),
    .running      (running),
    .expire       (expire_pulse)
  );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] reload_val,
  input logic             sw_start,
  input logic             sw_stop,
  input logic             tx_auto_en,
  input logic             tx_first_bit,
  input logic             rx_auto_en,
  input logic             rx_begin,
  input logic             auto_restart,
  input logic [CNT_W-1:0] count,
  input logic             running,
  input logic             expire_pulse
);
  logic start_any;
  assign start_any = sw_start | (tx_auto_en & tx_first_bit) | (rx_auto_en & rx_begin);

  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_any && !sw_stop) |=> (running && count == $past(reload_val))); // R3
  AST_TX_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && tx_first_bit && !tx_auto_en && !sw_start && !(rx_auto_en && rx_begin)) |=> !running); // R4
  AST_RX_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && rx_begin && !rx_auto_en && !sw_start && !(tx_auto_en && tx_first_bit)) |=> !running); // R5
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_stop |=> !running); // R6
  AST_STOP_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    sw_stop |=> $stable(count)); // R6
  AST_EXPIRE_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> !expire_pulse); // R7
  AST_EXPIRE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !auto_restart && !start_any) |=> (expire_pulse |-> (!running && count == '0))); // R7
  AST_AUTO_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (running && auto_restart && !sw_stop) |=> running); // R8
endmodule

bind tick_reload_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reload_val   (reload_val),
  .sw_start     (sw_start),
  .sw_stop      (sw_stop),
  .tx_auto_en   (tx_auto_en),
  .tx_first_bit (tx_first_bit),
  .rx_auto_en   (rx_auto_en),
  .rx_begin     (rx_begin),
  .auto_restart (auto_restart),
  .count        (count),
  .running      (running),
  .expire_pulse (expire_pulse)
);

// File: tb/tick_reload_timer_tb_top.sv
`timescale 1ns/1ps
module tick_reload_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] div_exp;
  logic [7:0] reload_val;
  logic       sw_start, sw_stop, tx_auto_en, tx_first_bit;
  logic       rx_auto_en, rx_begin, auto_restart;
  logic [7:0] count, count_c;
  logic       running, expire_pulse, running_c, expire_c;

  int n_chk = 0;
  int n_bad = 0;

  // model state
  logic [7:0] m_cnt;
  logic       m_run, m_irq;
  int         m_el;

  always #10 clk = ~clk;

  tick_reload_timer dut_i (
    .clk(clk), .rst_n(rst_n), .div_exp(div_exp), .reload_val(reload_val),
    .sw_start(sw_start), .sw_stop(sw_stop), .tx_auto_en(tx_auto_en),
    .tx_first_bit(tx_first_bit), .rx_auto_en(rx_auto_en), .rx_begin(rx_begin),
    .auto_restart(auto_restart), .count(count), .running(running),
    .expire_pulse(expire_pulse));

  tick_reload_timer #(.MAX_EXP(3)) dut_clamp_i (
    .clk(clk), .rst_n(rst_n), .div_exp(div_exp), .reload_val(reload_val),
    .sw_start(sw_start), .sw_stop(sw_stop), .tx_auto_en(tx_auto_en),
    .tx_first_bit(tx_first_bit), .rx_auto_en(rx_auto_en), .rx_begin(rx_begin),
    .auto_restart(auto_restart), .count(count_c), .running(running_c),
    .expire_pulse(expire_c));

  function automatic int period(input logic [4:0] e, input int max_e);
    int k = (int'(e) > max_e) ? max_e : int'(e);
    return 1 << k;
  endfunction

  function automatic logic start_seen();
    return sw_start | (tx_auto_en & tx_first_bit) | (rx_auto_en & rx_begin);
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    m_irq = 1'b0;
    if (!rst_n) begin
      m_cnt = '0; m_run = 1'b0; m_el = 0;
    end else if (sw_stop) begin
      m_run = 1'b0;
    end else if (start_seen()) begin
      m_run = 1'b1; m_cnt = reload_val; m_el = 0;
    end else if (m_run) begin
      m_el++;
      if (m_el == period(div_exp, 21)) begin
        m_el = 0;
        if (m_cnt <= 8'd1) begin
          m_irq = 1'b1;
          if (auto_restart) m_cnt = reload_val;
          else begin m_cnt = '0; m_run = 1'b0; end
        end else m_cnt = m_cnt - 8'd1;
      end
    end
  endtask

  // one clock: model follows the edge, outputs compared on the falling edge
  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(count == m_cnt, "R2 model count", count, m_cnt);
    chk(running == m_run, "R3 model running", running, m_run);
    chk(expire_pulse == m_irq, "R7 model expiry", expire_pulse, m_irq);
  endtask

  task automatic quiet();
    sw_start = 0; sw_stop = 0; tx_first_bit = 0; rx_begin = 0;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed = 32'h1F3C;
    void'($urandom(seed));
    rst_n = 0; div_exp = 0; reload_val = 0; auto_restart = 0;
    tx_auto_en = 0; rx_auto_en = 0; quiet();
    m_cnt = 0; m_run = 0; m_irq = 0; m_el = 0;
    repeat (3) @(negedge clk);
    chk(count == 0 && !running && !expire_pulse, "R1 in reset", {count, running, expire_pulse}, 0);
    rst_n = 1;
    cyc();
    chk(count == 0 && !running && !expire_pulse, "R1 after release", {count, running, expire_pulse}, 0);

    // R3 / R2 / R7: exponent 2, reload 3
    div_exp = 2; reload_val = 3; sw_start = 1; cyc(); quiet();
    chk(running && count == 3, "R3 start load", count, 3);
    wait_n(3);
    chk(count == 3, "R2 before first tick", count, 3);
    cyc();
    chk(count == 2, "R2 first tick", count, 2);
    wait_n(8);
    chk(expire_pulse && !running && count == 0, "R7 expiry", {count, running, expire_pulse}, 1);
    cyc();
    chk(!expire_pulse, "R7 single pulse", expire_pulse, 0);

    // R4
    tx_auto_en = 0; tx_first_bit = 1; cyc(); quiet();
    chk(!running && count == 0, "R4 tx disabled", running, 0);
    tx_auto_en = 1; reload_val = 9; tx_first_bit = 1; cyc(); quiet();
    chk(running && count == 9, "R4 tx enabled", count, 9);

    // R6
    wait_n(10);
    sw_stop = 1; cyc(); quiet();
    chk(!running && count == 7, "R6 stop freezes", count, 7);
    wait_n(9);
    chk(!running && count == 7, "R6 stays frozen", count, 7);
    sw_stop = 1; sw_start = 1; cyc(); quiet();
    chk(!running && count == 7, "R6 stop beats start", running, 0);
    tx_auto_en = 0;

    // R5
    rx_auto_en = 0; rx_begin = 1; cyc(); quiet();
    chk(!running, "R5 rx disabled", running, 0);
    rx_auto_en = 1; reload_val = 5; rx_begin = 1; cyc(); quiet();
    chk(running && count == 5, "R5 rx enabled", count, 5);
    sw_stop = 1; cyc(); quiet(); rx_auto_en = 0;

    // R8: exponent 0, reload 2, auto-restart
    div_exp = 0; reload_val = 2; auto_restart = 1; sw_start = 1; cyc(); quiet();
    cyc();
    chk(count == 1, "R8 step", count, 1);
    cyc();
    chk(expire_pulse && running && count == 2, "R8 reload on expiry", count, 2);
    reload_val = 1; wait_n(3);
    chk(expire_pulse && running && count == 1, "R8 back-to-back", count, 1);
    auto_restart = 0; sw_stop = 1; cyc(); quiet();

    // R9: restart mid-period
    div_exp = 2; reload_val = 4; sw_start = 1; cyc(); quiet();
    wait_n(6);
    chk(count == 3, "R9 before restart", count, 3);
    sw_start = 1; cyc(); quiet();
    chk(count == 4, "R9 reload", count, 4);
    wait_n(3);
    chk(count == 4, "R9 divider cleared", count, 4);
    cyc();
    chk(count == 3, "R9 full period", count, 3);
    sw_stop = 1; cyc(); quiet();

    // R7 with reload 0
    div_exp = 1; reload_val = 0; sw_start = 1; cyc(); quiet();
    cyc();
    chk(!expire_pulse && running, "R7 zero reload wait", running, 1);
    cyc();
    chk(expire_pulse && !running && count == 0, "R7 zero reload expiry", expire_pulse, 1);

    // R10: clamp on second instance (limit 3)
    div_exp = 7; reload_val = 2; sw_start = 1; cyc(); quiet();
    wait_n(7);
    chk(count_c == 2, "R10 clamp before tick", count_c, 2);
    cyc();
    chk(count_c == 1, "R10 clamped period 8", count_c, 1);
    chk(count == 2, "R10 unclamped still waiting", count, 2);
    sw_stop = 1; cyc(); quiet();

    // random phase
    for (int i = 0; i < 8000; i++) begin
      int r = $urandom_range(0, 99);
      quiet();
      if (r < 3) begin
        sw_start = 1;
        div_exp = 5'($urandom_range(0, 3));
      end else if (r < 5) sw_stop = 1;
      else if (r < 8) tx_first_bit = 1;
      else if (r < 11) rx_begin = 1;
      if ($urandom_range(0, 49) == 0) tx_auto_en = ~tx_auto_en;
      if ($urandom_range(0, 49) == 0) rx_auto_en = ~rx_auto_en;
      if ($urandom_range(0, 99) == 0) auto_restart = ~auto_restart;
      if ($urandom_range(0, 9) == 0) reload_val = 8'($urandom_range(0, 6));
      // keep the exponent fixed for an event start too
      if (!sw_start && !sw_stop && (tx_auto_en & tx_first_bit | rx_auto_en & rx_begin))
        div_exp = div_exp;
      cyc();
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule